// File: doc/BRIEF.md
# Programmable Read Latency Scheduler

This block sits on the controller side of a double-data-rate memory interface. It watches the READ command strobe and, for each read it accepts, opens a data-valid window. The window opens exactly when the first read data beat is due and stays open for one burst. The delay from command to first beat is the sum of a programmable CAS latency and a posted additive latency. Both are whole clock cycles. One clock before a burst that does not run straight on from the previous one, the block raises a strobe-preamble indication, so the capture path can arm itself.

Several reads may be in flight at once, because the total latency is usually longer than a burst period. Reads spaced exactly one burst period apart produce one continuous valid window. The latency configuration is sampled only while nothing is in flight. A value that is not a permitted latency is reported on an error flag, and while it is loaded no read is scheduled.

Top module: `rd_lat_sched`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every pending read. `data_valid` and `dqs_preamble` are low from the following cycle onward, and reads accepted before the reset never produce a window.
- R2: A configuration is legal when `cfg_cl` is in 3..7 and `cfg_al` is in 0..4. While an illegal configuration is active, `cfg_err` is high, every READ is ignored and no window opens. While a legal configuration is active, `cfg_err` is low.
- R3: A READ accepted at clock edge n, with active latencies CL and AL, drives `data_valid` high in the cycle that starts at edge n+CL+AL and not earlier.
- R4: The window lasts half the burst length in clock cycles: 2 cycles when `cfg_bl8`=0 (4 beats) and 4 cycles when `cfg_bl8`=1 (8 beats).
- R5: `dqs_preamble` is high for exactly the one cycle before the first valid cycle of a burst, when `data_valid` is low in that cycle. It is never high at any other time.
- R6: Two reads accepted exactly one burst period apart produce an unbroken `data_valid` window with no preamble between the bursts.
- R7: A READ that arrives less than one burst period (2 or 4 cycles, per `cfg_bl8`) after the last accepted READ is dropped and produces no window.
- R8: The configuration inputs are adopted on the first clock edge at which no read is in flight and no READ is being accepted. A change presented while reads are pending affects neither those reads nor reads accepted before the pipeline drains.
- R9: Reads whose windows are still pending while later reads are accepted, up to CL+AL cycles of overlap, each emerge at their own correct time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_cmd | input | 1 | READ command strobe, sampled at each rising edge |
| cfg_cl | input | 3 | Requested CAS latency in cycles (legal 3..7) |
| cfg_al | input | 3 | Requested additive latency in cycles (legal 0..4) |
| cfg_bl8 | input | 1 | Burst length select: 0 = 4 beats, 1 = 8 beats |
| data_valid | output | 1 | High for every clock cycle that carries read data beats |
| dqs_preamble | output | 1 | High in the cycle before a burst that follows an idle cycle |
| cfg_err | output | 1 | Active configuration holds an illegal latency value |

## Verification
On every cycle the embedded assertions check that a preamble is always followed by a valid cycle and never falls inside a burst. They also check that a burst start never lands on a burst with more than one cycle left, that two reads are never accepted on neighbouring edges, that an error configuration leaves the pipeline and window empty, and that the active configuration stays frozen while anything is pending. The exact arrival cycle, the window length and the dropping of early reads depend on the latency values chosen. So does the deferred adoption of a configuration change. The bench therefore shows these behaviours with a sweep over every CL, AL and burst-length code, legal and illegal, comparing each cycle against a schedule it computes arithmetically. It also runs dedicated scenarios for a configuration change while reads are in flight and for a reset while reads are pending.

// File: rtl/rls_pkg.sv
`timescale 1ns/1ps
package rls_pkg;
  parameter int CL_W   = 3;
  parameter int AL_W   = 3;
  parameter int CL_MIN = 3;
  parameter int CL_MAX = 7;
  parameter int AL_MAX = 4;

  localparam int DEPTH  = CL_MAX + AL_MAX + 2;
  localparam int LAT_W  = $clog2(DEPTH + 1);
  localparam int BCNT_W = 3;

  typedef struct packed {
    logic [CL_W-1:0] cl;
    logic [AL_W-1:0] al;
    logic            bl8;
  } rls_cfg_t;

  // legality of a latency setting
  function automatic logic cfg_legal(rls_cfg_t c);
    return (int'(c.cl) >= CL_MIN) && (int'(c.cl) <= CL_MAX) && (int'(c.al) <= AL_MAX);
  endfunction

  // command-to-first-beat distance in cycles
  function automatic logic [LAT_W-1:0] read_lat(rls_cfg_t c);
    return LAT_W'(c.cl) + LAT_W'(c.al);
  endfunction

  // clock cycles occupied by one burst (two beats per cycle)
  function automatic logic [BCNT_W-1:0] burst_cyc(rls_cfg_t c);
    return c.bl8 ? BCNT_W'(4) : BCNT_W'(2);
  endfunction

  // slots of the pipeline that still hold a live read for this latency
  function automatic logic [DEPTH-1:0] live_mask(logic [LAT_W-1:0] lat);
    logic [DEPTH-1:0] m;
    for (int i = 0; i < DEPTH; i++) m[i] = (i < int'(lat));
    return m;
  endfunction
endpackage

// File: rtl/rls_cfg_hold.sv
`timescale 1ns/1ps
module rls_cfg_hold
  import rls_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  rls_cfg_t cfg_in,
  input  logic     idle,
  output rls_cfg_t cfg_act,
  output logic     cfg_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_act.cl  <= CL_W'(CL_MIN);
      cfg_act.al  <= '0;
      cfg_act.bl8 <= 1'b0;
    end else if (idle) begin
      cfg_act <= cfg_in;
    end
  end

  assign cfg_err = !cfg_legal(cfg_act);
endmodule

// File: rtl/rls_issue_gate.sv
`timescale 1ns/1ps
module rls_issue_gate
  import rls_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_cmd,
  input  logic              cfg_err,
  input  logic [BCNT_W-1:0] bcyc,
  output logic              accept
);
  logic [BCNT_W-1:0] gap_q;
  logic              gap_clear;

  assign gap_clear = (gap_q == '0);
  assign accept    = rd_cmd && !cfg_err && gap_clear;

  always_ff @(posedge clk) begin
    if (rst)              gap_q <= '0;
    else if (accept)      gap_q <= bcyc - BCNT_W'(1);
    else if (!gap_clear)  gap_q <= gap_q - BCNT_W'(1);
  end

  // R7: bursts are at least two cycles long, so accepts never sit on neighbouring edges
  assert_no_double_issue_R7: assert property (@(posedge clk) disable iff (rst)
    accept |=> !accept);
endmodule

// File: rtl/rls_slot_pipe.sv
`timescale 1ns/1ps
module rls_slot_pipe
  import rls_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [LAT_W-1:0] lat,
  output logic             start,
  output logic             pre_tap,
  output logic             live
);
  logic [DEPTH-1:0] slot_q;
  logic [DEPTH-1:0] keep;

  assign keep = live_mask(lat);

  // one bit per cycle of age; bits older than the latency are dropped
  always_ff @(posedge clk) begin
    if (rst) slot_q <= '0;
    else     slot_q <= {slot_q[DEPTH-2:0], accept} & keep;
  end

  always_comb begin
    start   = 1'b0;
    pre_tap = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i == int'(lat) - 1) start   = slot_q[i];
      if (i == int'(lat) - 2) pre_tap = slot_q[i];
    end
  end

  assign live = |slot_q;

  // R9: an accepted read occupies the youngest slot one cycle later
  assert_slot_entry_R9: assert property (@(posedge clk) disable iff (rst)
    accept |=> live);
endmodule

// File: rtl/rls_burst_win.sv
`timescale 1ns/1ps
module rls_burst_win
  import rls_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              pre_tap,
  input  logic [BCNT_W-1:0] bcyc,
  output logic              data_valid,
  output logic              preamble,
  output logic              busy
);
  logic [BCNT_W-1:0] rem_q;
  logic [BCNT_W-1:0] rem_nx;
  logic              pre_q;

  always_comb begin
    if (start)              rem_nx = bcyc;
    else if (rem_q != '0)   rem_nx = rem_q - BCNT_W'(1);
    else                    rem_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      pre_q <= 1'b0;
    end else begin
      rem_q <= rem_nx;
      pre_q <= pre_tap && (rem_nx == '0);
    end
  end

  assign data_valid = (rem_q != '0);
  assign preamble   = pre_q;
  assign busy       = data_valid;

  // R5: a preamble cycle is always followed by data
  assert_pre_leads_data_R5: assert property (@(posedge clk) disable iff (rst)
    preamble |=> data_valid);
  // R6: no preamble inside a running burst
  assert_pre_outside_burst_R6: assert property (@(posedge clk) disable iff (rst)
    preamble |-> !data_valid);
  // R4: a burst start opens the window on the next cycle
  assert_start_opens_R4: assert property (@(posedge clk) disable iff (rst)
    start |=> data_valid);
  // R7: a new burst only lands on the last cycle of the previous one or later
  assert_no_collision_R7: assert property (@(posedge clk) disable iff (rst)
    start |-> (rem_q <= BCNT_W'(1)));
  // R1: reset leaves both outputs low
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!data_valid && !preamble));
endmodule

// File: rtl/rd_lat_sched.sv
`timescale 1ns/1ps
module rd_lat_sched
  import rls_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_cmd,
  input  logic [CL_W-1:0] cfg_cl,
  input  logic [AL_W-1:0] cfg_al,
  input  logic            cfg_bl8,
  output logic            data_valid,
  output logic            dqs_preamble,
  output logic            cfg_err
);
  rls_cfg_t          cfg_req;
  rls_cfg_t          cfg_act;
  logic              accept;
  logic              pipe_live;
  logic              win_busy;
  logic              burst_start;
  logic              pre_tap;
  logic              idle;
  logic [LAT_W-1:0]  lat;
  logic [BCNT_W-1:0] bcyc;

  assign cfg_req.cl  = cfg_cl;
  assign cfg_req.al  = cfg_al;
  assign cfg_req.bl8 = cfg_bl8;

  assign lat  = read_lat(cfg_act);
  assign bcyc = burst_cyc(cfg_act);
  assign idle = !pipe_live && !win_busy && !accept;

  rls_cfg_hold u_cfg (
    .clk(clk), .rst(rst), .cfg_in(cfg_req), .idle(idle),
    .cfg_act(cfg_act), .cfg_err(cfg_err)
  );

  rls_issue_gate u_gate (
    .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .cfg_err(cfg_err),
    .bcyc(bcyc), .accept(accept)
  );

  rls_slot_pipe u_pipe (
    .clk(clk), .rst(rst), .accept(accept), .lat(lat),
    .start(burst_start), .pre_tap(pre_tap), .live(pipe_live)
  );

  rls_burst_win u_win (
    .clk(clk), .rst(rst), .start(burst_start), .pre_tap(pre_tap),
    .bcyc(bcyc), .data_valid(data_valid), .preamble(dqs_preamble),
    .busy(win_busy)
  );

  // R8: latency settings stay frozen while anything is pending
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (pipe_live || win_busy) |=> $stable(cfg_act));
  // R2: an illegal configuration never coexists with scheduled work
  assert_err_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!pipe_live && !data_valid));
endmodule

// File: tb/rd_lat_sched_bench.sv
`timescale 1ns/1ps
module rd_lat_sched_bench;
  localparam int NCYC = 16384;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_cmd = 1'b0;
  logic [2:0] cfg_cl = 3'd3;
  logic [2:0] cfg_al = 3'd0;
  logic       cfg_bl8 = 1'b0;
  logic       data_valid, dqs_preamble, cfg_err;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int next_ok = 0;
  int m_cl = 3, m_al = 0, m_b = 2;
  string tag = "R1";
  bit exp_v [NCYC];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rd_lat_sched u_rd_lat_sched (
    .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .cfg_cl(cfg_cl), .cfg_al(cfg_al),
    .cfg_bl8(cfg_bl8), .data_valid(data_valid), .dqs_preamble(dqs_preamble),
    .cfg_err(cfg_err)
  );

  function automatic bit m_legal();
    return (m_cl >= 3) && (m_cl <= 7) && (m_al <= 4);
  endfunction

  task automatic chk(input bit ok, input string what, input int got, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at cycle %0d: got %0d expected %0d", tag, what, cyc, got, expv);
    end
  endtask

  // one cycle: compare outputs, then drive the READ strobe and reset
  task automatic step(input bit rd, input bit rs);
    bit ev, ep;
    @(negedge clk);
    ev = exp_v[cyc];
    ep = exp_v[cyc+1] && !exp_v[cyc];
    chk(data_valid === ev, "data_valid", int'(data_valid), int'(ev));
    chk(dqs_preamble === ep, "dqs_preamble", int'(dqs_preamble), int'(ep));
    rd_cmd = rd;
    rst = rs;
    if (rs) begin
      for (int k = cyc + 1; k < NCYC; k++) exp_v[k] = 1'b0;
      next_ok = 0;
    end else if (rd && m_legal() && (cyc + 1 >= next_ok)) begin
      for (int k = 0; k < m_b; k++) exp_v[cyc + 1 + m_cl + m_al + k] = 1'b1;
      next_ok = cyc + 1 + m_b;
    end
  endtask

  task automatic set_cfg(input int cl, input int al, input bit b8, input bit adopt);
    cfg_cl = 3'(cl);
    cfg_al = 3'(al);
    cfg_bl8 = b8;
    if (adopt) begin
      m_cl = cl; m_al = al; m_b = b8 ? 4 : 2;
    end
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);

    // R2 R3 R4 R5 R6 R7 R9: sweep every latency and burst code
    for (int cl = 0; cl < 8; cl++)
      for (int al = 0; al < 8; al++)
        for (int b = 0; b < 2; b++) begin
          int plen;
          set_cfg(cl, al, b[0], 1'b1);
          tag = "R2";
          step(1'b0, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
          chk(cfg_err === !m_legal(), "cfg_err", int'(cfg_err), int'(!m_legal()));
          tag = "R3 R4 R5 R6 R7 R9";
          plen = 3 * m_b + 4;
          for (int i = 0; i < plen; i++)
            step((i == 0) || (i == 1) || (i == m_b) || (i == 2 * m_b + 1), 1'b0);
          for (int i = 0; i < m_cl + m_al + m_b + 3; i++) step(1'b0, 1'b0);
        end

    // R8: configuration change presented while reads are in flight
    tag = "R8";
    set_cfg(5, 2, 1'b0, 1'b1);
    step(1'b0, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    set_cfg(3, 0, 1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    for (int i = 0; i < 14; i++) step(1'b0, 1'b0);
    set_cfg(3, 0, 1'b1, 1'b1);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0);

    // R1: reset while reads are pending
    tag = "R1";
    set_cfg(6, 3, 1'b0, 1'b1);
    step(1'b0, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    for (int i = 0; i < 16; i++) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    for (int i = 0; i < 16; i++) step(1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, got 0 expected 1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule